// File: doc/BRIEF.md
# Ternary Weight Dot-Product Accumulator

This block computes dot products for neural network layers whose weights are limited to minus one, zero and plus one. It has no multiplier. Each clock it can take one signed 32-bit activation and a 2-bit weight code. A three-stage pipeline handles the element. The first stage turns the code into an add, subtract or skip control. The second stage sign-extends the activation to the accumulator width and negates it or zeroes it as the control requires. The third stage adds the result into a 512-bit two's complement accumulator. Nothing is rounded or truncated along the way.

An element flagged as last closes the current dot product. Two cycles after that element is accepted, the full accumulator value is presented for one cycle with a valid pulse. The accumulator starts again from zero, so the first element of the next dot product can follow the last element of the previous one with no gap.

A synchronous clear input empties the pipeline and zeroes the sum. An unused weight code behaves as zero and sets a sticky error flag.

Top module: `ternary_mac_pipe`

## Requirements
- R1: Weight code 2'b01 (+1) adds the activation, sign-extended from 32 bits, to the running sum.
- R2: Weight code 2'b11 (-1) subtracts the sign-extended activation from the running sum.
- R3: Weight code 2'b00 (0) leaves the running sum unchanged for that element.
- R4: Weight code 2'b10 is reserved and contributes zero. Accepting it sets err_o in the following cycle. err_o then stays high until reset; clr_i does not lower it.
- R5: The sum is exact 512-bit two's complement. Totals beyond the 32-bit activation range appear in res_o without wrap or rounding.
- R6: While clr_i is low, in_ready_o is high, so one element is accepted every cycle. Cycles with in_valid_i low add nothing and do not alter the result.
- R7: If an element with in_last_i set is accepted at clock edge n, res_valid_o is high for exactly the cycle after edge n+2. res_o then carries the complete sum and holds it until the next result.
- R8: A new dot product may begin in the cycle right after a last element. Its sum starts from zero, so consecutive results can appear in consecutive cycles.
- R9: clr_i zeroes the accumulator and discards every element still in the pipeline. No result is produced for discarded elements, and any result due at that edge is suppressed. in_ready_o is low while clr_i is high.
- R10: After reset, res_valid_o and err_o are low, res_o is zero, in_ready_o is high and the pipeline is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of sum and pipeline |
| in_valid_i | input | 1 | Input element valid |
| in_ready_o | output | 1 | Input element may be accepted |
| in_act_i | input | 32 | Signed activation |
| in_wgt_i | input | 2 | Ternary weight code |
| in_last_i | input | 1 | Element closes the dot product |
| res_valid_o | output | 1 | One-cycle result pulse |
| res_o | output | 512 | Exact dot-product sum |
| err_o | output | 1 | Sticky reserved-code flag |

## Verification
The assertions check the following on every cycle:
- An accepted last element produces a result pulse two cycles later unless a clear intervenes, and no pulse appears without a closing element in the stage before.
- A reserved code raises the error flag, and the flag never falls.
- A clear leaves the accumulator at zero, and so does the close of each dot product.

Only the bench scenarios can show the numerical exactness of the sums:
- mixed add, subtract and skip patterns;
- a long run of extreme negative activations whose total exceeds the 32-bit range;
- the correct restart from zero across back-to-back and bubbled vectors.

The bench scenarios also show that elements flushed by a mid-vector clear never reach a later result.

// File: rtl/tern_mac_pkg.sv
package tern_mac_pkg;
  typedef enum logic [1:0] {
    OP_NOP = 2'd0,
    OP_ADD = 2'd1,
    OP_SUB = 2'd2
  } tern_op_e;

  localparam logic [1:0] WGT_ZERO = 2'b00;
  localparam logic [1:0] WGT_POS  = 2'b01;
  localparam logic [1:0] WGT_RSV  = 2'b10;
  localparam logic [1:0] WGT_NEG  = 2'b11;

  function automatic tern_op_e wgt_to_op(input logic [1:0] code);
    unique case (code)
      WGT_POS: wgt_to_op = OP_ADD;
      WGT_NEG: wgt_to_op = OP_SUB;
      default: wgt_to_op = OP_NOP;
    endcase
  endfunction
endpackage

// File: rtl/tern_decode.sv
module tern_decode
  import tern_mac_pkg::*;
#(
  parameter int ACT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             take_i,
  input  logic [ACT_W-1:0] act_i,
  input  logic [1:0]       wgt_i,
  input  logic             last_i,
  output logic             vld_o,
  output tern_op_e         op_o,
  output logic [ACT_W-1:0] act_o,
  output logic             last_o,
  output logic             err_o
);
  logic     rsv_hit;
  tern_op_e op_d;

  assign op_d    = wgt_to_op(wgt_i);
  assign rsv_hit = take_i && (wgt_i == WGT_RSV);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      op_o   <= OP_NOP;
      act_o  <= '0;
      last_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      if (rsv_hit) err_o <= 1'b1;
      if (flush_i) begin
        vld_o  <= 1'b0;
        last_o <= 1'b0;
      end else begin
        vld_o  <= take_i;
        last_o <= take_i && last_i;
        if (take_i) begin
          op_o  <= op_d;
          act_o <= act_i;
        end
      end
    end
  end
endmodule

// File: rtl/tern_addsub.sv
module tern_addsub
  import tern_mac_pkg::*;
#(
  parameter int ACT_W = 32,
  parameter int ACC_W = 512
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             vld_i,
  input  tern_op_e         op_i,
  input  logic [ACT_W-1:0] act_i,
  input  logic             last_i,
  output logic             vld_o,
  output logic [ACC_W-1:0] term_o,
  output logic             last_o
);
  localparam int EXT_W = ACC_W - ACT_W;

  logic [ACC_W-1:0] ext;
  logic [ACC_W-1:0] term_d;

  generate
    if (EXT_W > 0) begin : g_ext
      assign ext = {{EXT_W{act_i[ACT_W-1]}}, act_i};
    end else begin : g_same
      assign ext = act_i[ACC_W-1:0];
    end
  endgenerate

  always_comb begin
    unique case (op_i)
      OP_ADD:  term_d = ext;
      OP_SUB:  term_d = '0 - ext;
      default: term_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      term_o <= '0;
      last_o <= 1'b0;
    end else if (flush_i) begin
      vld_o  <= 1'b0;
      last_o <= 1'b0;
    end else begin
      vld_o  <= vld_i;
      last_o <= vld_i && last_i;
      if (vld_i) term_o <= term_d;
    end
  end
endmodule

// File: rtl/tern_accum.sv
module tern_accum #(
  parameter int ACC_W = 512
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             vld_i,
  input  logic [ACC_W-1:0] term_i,
  input  logic             last_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             res_vld_o,
  output logic [ACC_W-1:0] res_o
);
  logic [ACC_W-1:0] sum;

  assign sum = acc_o + term_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o     <= '0;
      res_vld_o <= 1'b0;
      res_o     <= '0;
    end else if (flush_i) begin
      acc_o     <= '0;
      res_vld_o <= 1'b0;
    end else begin
      res_vld_o <= vld_i && last_i;
      if (vld_i) begin
        if (last_i) begin
          res_o <= sum;
          acc_o <= '0;
        end else begin
          acc_o <= sum;
        end
      end
    end
  end
endmodule

// File: rtl/ternary_mac_pipe.sv
module ternary_mac_pipe
  import tern_mac_pkg::*;
#(
  parameter int ACT_W = 32,
  parameter int ACC_W = 512
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [ACT_W-1:0] in_act_i,
  input  logic [1:0]       in_wgt_i,
  input  logic             in_last_i,
  output logic             res_valid_o,
  output logic [ACC_W-1:0] res_o,
  output logic             err_o
);
  logic             take;
  logic             s1_vld, s1_last;
  tern_op_e         s1_op;
  logic [ACT_W-1:0] s1_act;
  logic             s2_vld, s2_last;
  logic [ACC_W-1:0] s2_term;
  logic [ACC_W-1:0] acc_q;

  assign in_ready_o = !clr_i;
  assign take       = in_valid_i && in_ready_o;

  tern_decode #(.ACT_W(ACT_W)) u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (clr_i),
    .take_i  (take),
    .act_i   (in_act_i),
    .wgt_i   (in_wgt_i),
    .last_i  (in_last_i),
    .vld_o   (s1_vld),
    .op_o    (s1_op),
    .act_o   (s1_act),
    .last_o  (s1_last),
    .err_o   (err_o)
  );

  tern_addsub #(.ACT_W(ACT_W), .ACC_W(ACC_W)) u_as (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (clr_i),
    .vld_i   (s1_vld),
    .op_i    (s1_op),
    .act_i   (s1_act),
    .last_i  (s1_last),
    .vld_o   (s2_vld),
    .term_o  (s2_term),
    .last_o  (s2_last)
  );

  tern_accum #(.ACC_W(ACC_W)) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (clr_i),
    .vld_i     (s2_vld),
    .term_i    (s2_term),
    .last_i    (s2_last),
    .acc_o     (acc_q),
    .res_vld_o (res_valid_o),
    .res_o     (res_o)
  );
endmodule

// File: rtl/ternary_mac_chk.sv
module ternary_mac_chk #(
  parameter int ACC_W = 512
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_i,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic [1:0]       in_wgt_i,
  input logic             in_last_i,
  input logic             res_valid_o,
  input logic             err_o,
  input logic             s2_vld,
  input logic             s2_last,
  input logic [ACC_W-1:0] acc_q
);
  a_r7_result_after_two: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && in_last_i) ##1 !clr_i ##1 !clr_i |=> res_valid_o);

  a_r7_no_spurious_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(res_valid_o) |-> $past(s2_vld && s2_last));

  a_r4_err_on_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && in_wgt_i == 2'b10) |=> err_o);

  a_r4_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  a_r9_clear_zeroes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (acc_q == '0) && !res_valid_o);

  a_r8_restart_from_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s2_vld && s2_last) |=> (acc_q == '0));
endmodule

bind ternary_mac_pipe ternary_mac_chk #(.ACC_W(ACC_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .clr_i       (clr_i),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .in_wgt_i    (in_wgt_i),
  .in_last_i   (in_last_i),
  .res_valid_o (res_valid_o),
  .err_o       (err_o),
  .s2_vld      (s2_vld),
  .s2_last     (s2_last),
  .acc_q       (acc_q)
);

// File: tb/ternary_mac_pipe_test.sv
`timescale 1ns/1ps
module ternary_mac_pipe_test;
  localparam int ACT_W = 32;
  localparam int ACC_W = 512;
  localparam int NV    = 12;

  // {last, weight code, activation}
  localparam logic [34:0] TBL [NV] = '{
    {1'b0, 2'b01, 32'd5},
    {1'b0, 2'b01, 32'd7},
    {1'b1, 2'b11, 32'd3},
    {1'b0, 2'b00, 32'd100},
    {1'b0, 2'b11, 32'hFFFFFFEC},
    {1'b1, 2'b01, 32'hFFFFFFFF},
    {1'b1, 2'b01, 32'h7FFFFFFF},
    {1'b0, 2'b11, 32'h80000000},
    {1'b1, 2'b11, 32'h80000000},
    {1'b0, 2'b01, 32'd1},
    {1'b0, 2'b00, 32'hFFFFFFFB},
    {1'b1, 2'b00, 32'd9}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             clr = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [ACT_W-1:0] in_act = '0;
  logic [1:0]       in_wgt = '0;
  logic             in_last = 1'b0;
  logic             res_valid;
  logic [ACC_W-1:0] res;
  logic             err;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic [ACC_W-1:0] model_sum = '0;
  logic [ACC_W-1:0] exp_q[$];
  int               cyc_q[$];
  string            tag_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ternary_mac_pipe #(.ACT_W(ACT_W), .ACC_W(ACC_W)) uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .clr_i       (clr),
    .in_valid_i  (in_valid),
    .in_ready_o  (in_ready),
    .in_act_i    (in_act),
    .in_wgt_i    (in_wgt),
    .in_last_i   (in_last),
    .res_valid_o (res_valid),
    .res_o       (res),
    .err_o       (err)
  );

  task automatic check(input bit ok, input string what, input logic [ACC_W-1:0] act_v,
                       input logic [ACC_W-1:0] exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act_v, exp_v);
    end
  endtask

  // Result monitor: value and cycle of every pulse (R7)
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7/R9 unexpected result pulse", res, '0);
      end else begin
        logic [ACC_W-1:0] e;
        int ec;
        string t;
        e = exp_q.pop_front();
        ec = cyc_q.pop_front();
        t = tag_q.pop_front();
        check(res == e, {t, " R7 result value"}, res, e);
        check(cyc == ec + 2, {t, " R7 result cycle"}, ACC_W'(cyc), ACC_W'(ec + 2));
      end
    end
  end

  task automatic send(input logic [31:0] a, input logic [1:0] w, input logic l, input string tag);
    logic [ACC_W-1:0] ext;
    @(negedge clk);
    in_valid = 1'b1;
    in_act = a;
    in_wgt = w;
    in_last = l;
    @(posedge clk);
    #1;
    ext = {{(ACC_W-32){a[31]}}, a};
    if (w == 2'b01) model_sum = model_sum + ext;
    else if (w == 2'b11) model_sum = model_sum - ext;
    if (l) begin
      exp_q.push_back(model_sum);
      cyc_q.push_back(cyc);
      tag_q.push_back(tag);
      model_sum = '0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_last = 1'b0;
    end
  endtask

  task automatic do_clear();
    @(negedge clk);
    in_valid = 1'b0;
    clr = 1'b1;
    #1;
    check(in_ready == 1'b0, "R9 ready low during clear", ACC_W'(in_ready), '0);
    @(posedge clk);
    #1;
    while (cyc_q.size() > 0 && cyc_q[cyc_q.size()-1] >= cyc - 2) begin
      void'(exp_q.pop_back());
      void'(cyc_q.pop_back());
      tag_q.pop_back();
    end
    model_sum = '0;
    @(negedge clk);
    clr = 1'b0;
  endtask

  initial begin
    #1ms;
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(res_valid == 1'b0, "R10 res_valid after reset", ACC_W'(res_valid), '0);
    check(res == '0, "R10 res zero after reset", res, '0);
    check(err == 1'b0, "R10 err low after reset", ACC_W'(err), '0);
    check(in_ready == 1'b1, "R10/R6 ready high", ACC_W'(in_ready), 1);

    // Table walk: R1 R2 R3 R5 R8 (back-to-back vectors)
    for (int i = 0; i < NV; i++) begin
      send(TBL[i][31:0], TBL[i][33:32], TBL[i][34], "R1/R2/R3/R5/R8 table");
    end
    idle(4);

    // R8: single-element vectors in consecutive cycles
    send(32'd11, 2'b01, 1'b1, "R8 b2b");
    send(32'd22, 2'b11, 1'b1, "R8 b2b");
    send(32'd33, 2'b00, 1'b1, "R8 b2b");
    send(32'd44, 2'b01, 1'b1, "R8 b2b");
    idle(4);

    // R6: bubbles between elements
    send(32'd10, 2'b01, 1'b0, "R6 bubbles");
    idle(2);
    send(32'd4, 2'b11, 1'b0, "R6 bubbles");
    idle(3);
    send(32'd1, 2'b01, 1'b1, "R6 bubbles");
    idle(4);

    // R5: long run of -(-2^31) totals 300*2^31
    for (int i = 0; i < 300; i++) begin
      send(32'h80000000, 2'b11, (i == 299), "R5 wide");
    end
    idle(4);

    // R4: reserved code acts as zero and sets sticky error
    check(err == 1'b0, "R4 err low before reserved", ACC_W'(err), '0);
    send(32'd50, 2'b10, 1'b0, "R4 reserved");
    @(negedge clk);
    in_valid = 1'b0;
    check(err == 1'b1, "R4 err set", ACC_W'(err), 1);
    send(32'd6, 2'b01, 1'b1, "R4 reserved");
    idle(4);

    // R9: clear mid-vector then fresh vector
    send(32'd1000, 2'b01, 1'b0, "R9 flushed");
    send(32'd2000, 2'b01, 1'b0, "R9 flushed");
    do_clear();
    send(32'd4, 2'b01, 1'b1, "R9 after clear");
    idle(4);
    check(err == 1'b1, "R4 err survives clear", ACC_W'(err), 1);

    // R9: last element in flight when clear hits, no result must appear
    send(32'd77, 2'b01, 1'b1, "R9 in flight");
    do_clear();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(res_valid == 1'b0, "R9 no result after flush", ACC_W'(res_valid), '0);
    end

    idle(2);
    check(exp_q.size() == 0, "R7 all results seen", ACC_W'(exp_q.size()), '0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule